// File: doc/BRIEF.md
# Tagged Write Staging Buffer

This block sits on the write side of one port of a multi-bank memory crossbar. It lets the port keep several write commands in flight towards different banks at once, with no bank holding a lock on the port. Each write the port hands over is given a storage slot number. The write data goes into a small local memory at that slot. The command goes on towards the bank scheduler with the slot number attached.

Later, whenever it is ready to issue the write, the bank scheduler reads the data back out of the memory by slot number. The read frees the slot. The number of writes that can be outstanding at once is a parameter, `DEPTH`. When that many writes are pending, the port stalls until a bank has read one of them out.

The command and its data are taken in one valid/ready handshake. Slots are handed out in strict rotation, 0, 1, … `DEPTH`-1, 0, and so on. The data read port on the bank side has a latency of one cycle.

Top module: `wr_stage_buf`

## Requirements
- R1: After reset, the pending count is zero, `bk_cmd_slot` is 0, `bk_rd_valid` and `bk_rd_data` are 0, and `up_ready` follows `bk_cmd_ready`.
- R2: `up_ready` is high exactly when `bk_cmd_ready` is high and fewer than `DEPTH` writes are pending. `bk_cmd_valid` is high exactly when `up_valid` is high and fewer than `DEPTH` writes are pending. `bk_cmd_addr` equals `up_addr` in the same cycle.
- R3: `bk_cmd_slot` shows the slot that the next accepted write will use. It advances by one after each accepted write (`up_valid` and `up_ready` both high), wraps from `DEPTH`-1 to 0, and holds in every other cycle.
- R4: Each accepted write adds one to the pending count, and each counted bank read removes one. When both happen in the same cycle, the count is unchanged.
- R5: While `DEPTH` writes are pending, `up_ready` and `bk_cmd_valid` stay low, and no further write is taken until a bank read frees a slot.
- R6: A bank read with `bk_rd_en` high and slot k in cycle t drives `bk_rd_valid` high in cycle t+1. In that cycle `bk_rd_data` is the data of the most recent write accepted into slot k before cycle t.
- R7: A bank read made while no write is pending leaves the pending count at zero, so exactly `DEPTH` later writes are still taken before the port stalls.
- R8: In a cycle after one with `bk_rd_en` low, `bk_rd_valid` is 0 and `bk_rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Port offers a write command with data |
| up_ready | output | 1 | Write taken this cycle when `up_valid` is also high |
| up_addr | input | ADDR_W | Write address from the port |
| up_data | input | DATA_W | Write data from the port |
| bk_cmd_valid | output | 1 | Tagged command offered to the bank scheduler |
| bk_cmd_ready | input | 1 | Bank scheduler can take a command |
| bk_cmd_addr | output | ADDR_W | Address forwarded to the bank scheduler |
| bk_cmd_slot | output | IDX_W | Slot number that holds the command's data |
| bk_rd_en | input | 1 | Bank scheduler reads and frees a slot |
| bk_rd_slot | input | IDX_W | Slot to read |
| bk_rd_valid | output | 1 | `bk_rd_data` carries the result of the previous cycle's read |
| bk_rd_data | output | DATA_W | Data read from the slot |

## Verification
The first pattern fills the buffer back to back until it stalls, then frees slots out of order. This separates a correct per-slot store from one that returns data in arrival order, and shows the stall at exactly `DEPTH` pending writes.

Directed cycles then cover three cases. A write and a free in the same cycle tell a balanced count update apart from a double step. A lowered `bk_cmd_ready` or `up_valid` shows that the slot does not advance without a handshake. A free with nothing pending, followed by a full refill, exposes a count that underflows.

A long randomised run then mixes stalls from both sides with oldest-first frees that wrap the slot number many times. At every cycle it compares the ready and valid signals, the slot number and the read data against a queue-based model.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  // Next slot in rotation; wraps at depth (need not be a power of two).
  function automatic int unsigned slot_step(input int unsigned cur,
                                            input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

  // Occupancy after one cycle of allocation and release.
  function automatic int unsigned occ_next(input int unsigned cur,
                                           input logic        inc,
                                           input logic        dec);
    int unsigned r;
    r = cur;
    if (inc && !dec) r = cur + 1;
    if (dec && !inc) r = cur - 1;
    return r;
  endfunction

endpackage

// File: rtl/wsb_slot_alloc.sv
module wsb_slot_alloc #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic             free_i,
  output logic [IDX_W-1:0] slot_o,
  output logic [CNT_W-1:0] count_o,
  output logic             room_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [IDX_W-1:0] slot_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_i)
        slot_q <= IDX_W'(wsb_pkg::slot_step(int'(slot_q), DEPTH));
      cnt_q <= CNT_W'(wsb_pkg::occ_next(int'(cnt_q), alloc_i, free_i));
    end
  end

  assign slot_o  = slot_q;
  assign count_o = cnt_q;
  assign room_o  = (cnt_q < FULL);
endmodule

// File: rtl/wsb_cmd_gate.sv
module wsb_cmd_gate (
  input  logic up_valid_i,
  input  logic bk_ready_i,
  input  logic room_i,
  output logic up_ready_o,
  output logic bk_valid_o,
  output logic fire_o
);
  assign up_ready_o = bk_ready_i && room_i;
  assign bk_valid_o = up_valid_i && room_i;
  assign fire_o     = up_valid_i && bk_ready_i && room_i;
endmodule

// File: rtl/wsb_data_mem.sv
module wsb_data_mem #(
  parameter int DEPTH  = 6,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              raddr_ok;

  assign raddr_ok = (int'(raddr_i) < DEPTH);

  always_ff @(posedge clk) begin
    if (we_i && (int'(waddr_i) < DEPTH))
      store[waddr_i] <= wdata_i;
  end

  // Registered read: old contents are returned on a same-slot collision.
  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (re_i)
      rd_q <= raddr_ok ? store[raddr_i] : '0;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/wr_stage_buf.sv
module wr_stage_buf #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  output logic              bk_cmd_valid,
  input  logic              bk_cmd_ready,
  output logic [ADDR_W-1:0] bk_cmd_addr,
  output logic [IDX_W-1:0]  bk_cmd_slot,
  input  logic              bk_rd_en,
  input  logic [IDX_W-1:0]  bk_rd_slot,
  output logic              bk_rd_valid,
  output logic [DATA_W-1:0] bk_rd_data
);
  // Named internal events, also used by the bound checker.
  logic             alloc_fire;
  logic             free_fire;
  logic             has_room;
  logic [CNT_W-1:0] pend_cnt;
  logic             rd_valid_q;

  assign free_fire = bk_rd_en && (pend_cnt != '0);

  wsb_cmd_gate u_gate (
    .up_valid_i (up_valid),
    .bk_ready_i (bk_cmd_ready),
    .room_i     (has_room),
    .up_ready_o (up_ready),
    .bk_valid_o (bk_cmd_valid),
    .fire_o     (alloc_fire)
  );

  wsb_slot_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .alloc_i (alloc_fire),
    .free_i  (free_fire),
    .slot_o  (bk_cmd_slot),
    .count_o (pend_cnt),
    .room_o  (has_room)
  );

  wsb_data_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (alloc_fire),
    .waddr_i (bk_cmd_slot),
    .wdata_i (up_data),
    .re_i    (bk_rd_en),
    .raddr_i (bk_rd_slot),
    .rdata_o (bk_rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= bk_rd_en;
  end

  assign bk_rd_valid = rd_valid_q;
  assign bk_cmd_addr = up_addr;
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_ready,
  input logic             bk_cmd_valid,
  input logic             bk_cmd_ready,
  input logic [IDX_W-1:0] bk_cmd_slot,
  input logic             bk_rd_en,
  input logic             bk_rd_valid,
  input logic             alloc_fire,
  input logic             free_fire,
  input logic [CNT_W-1:0] pend_cnt
);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= DEPTH);

  a_r5_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pend_cnt) == DEPTH) |-> (!up_ready && !bk_cmd_valid));

  a_r2_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pend_cnt) < DEPTH && bk_cmd_ready) |-> up_ready);

  a_r3_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=>
      (int'(bk_cmd_slot) ==
       ((int'($past(bk_cmd_slot)) == DEPTH - 1) ? 0 : int'($past(bk_cmd_slot)) + 1)));

  a_r3_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_valid && up_ready) |=> $stable(bk_cmd_slot));

  a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !free_fire) |=> (int'(pend_cnt) == int'($past(pend_cnt)) + 1));

  a_r4_count_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && free_fire) |=> $stable(pend_cnt));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_rd_en && pend_cnt == '0 && !alloc_fire) |=> (pend_cnt == '0));

  a_r6_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd_en |=> bk_rd_valid);

  a_r8_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bk_rd_en |=> !bk_rd_valid);
endmodule

bind wr_stage_buf wsb_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wsb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_valid     (up_valid),
  .up_ready     (up_ready),
  .bk_cmd_valid (bk_cmd_valid),
  .bk_cmd_ready (bk_cmd_ready),
  .bk_cmd_slot  (bk_cmd_slot),
  .bk_rd_en     (bk_rd_en),
  .bk_rd_valid  (bk_rd_valid),
  .alloc_fire   (alloc_fire),
  .free_fire    (free_fire),
  .pend_cnt     (pend_cnt)
);

// File: tb/wr_stage_buf_bench.sv
`timescale 1ns/1ps
module wr_stage_buf_bench;
  localparam int DEPTH  = 6;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              up_valid = 1'b0;
  logic              up_ready;
  logic [ADDR_W-1:0] up_addr = '0;
  logic [DATA_W-1:0] up_data = '0;
  logic              bk_cmd_valid;
  logic              bk_cmd_ready = 1'b0;
  logic [ADDR_W-1:0] bk_cmd_addr;
  logic [IDX_W-1:0]  bk_cmd_slot;
  logic              bk_rd_en = 1'b0;
  logic [IDX_W-1:0]  bk_rd_slot = '0;
  logic              bk_rd_valid;
  logic [DATA_W-1:0] bk_rd_data;

  always #2.5 clk = ~clk;

  wr_stage_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr_stage_buf (
    .clk, .rst_n, .up_valid, .up_ready, .up_addr, .up_data,
    .bk_cmd_valid, .bk_cmd_ready, .bk_cmd_addr, .bk_cmd_slot,
    .bk_rd_en, .bk_rd_slot, .bk_rd_valid, .bk_rd_data
  );

  // Behavioural reference state
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;
  int          m_slot = 0;
  int          m_pend = 0;
  logic [31:0] m_mem [DEPTH];
  logic [31:0] exp_rd_data = '0;
  bit          exp_rd_valid = 0;
  int          live[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive at negedge, check combinational outputs, step model, check registered outputs.
  task automatic cyc(input bit v, input bit br, input logic [31:0] d, input bit re, input int rs);
    bit room, acc, fr;
    up_valid = v; bk_cmd_ready = br; up_data = d; up_addr = d[23:0] ^ 24'h5A5A5A;
    bk_rd_en = re; bk_rd_slot = IDX_W'(rs);
    #1;
    room = (m_pend < DEPTH);
    check((m_pend == DEPTH) ? "R5 up_ready at full" : "R2 up_ready", 64'(up_ready), 64'(br && room));
    check((m_pend == DEPTH) ? "R5 bk_cmd_valid at full" : "R2 bk_cmd_valid", 64'(bk_cmd_valid), 64'(v && room));
    check("R3 bk_cmd_slot", 64'(bk_cmd_slot), 64'(m_slot));
    check("R2 bk_cmd_addr", 64'(bk_cmd_addr), 64'(up_addr));
    acc = v && br && room;
    fr  = re && (m_pend > 0);
    @(posedge clk);
    exp_rd_valid = re;
    if (re) exp_rd_data = m_mem[rs];
    if (fr) begin
      for (int k = 0; k < live.size(); k++)
        if (live[k] == rs) begin live.delete(k); break; end
    end
    if (acc) begin
      m_mem[m_slot] = d;
      live.push_back(m_slot);
      m_slot = (m_slot + 1) % DEPTH;
    end
    m_pend = m_pend + int'(acc) - int'(fr);
    @(negedge clk);
    check(re ? "R6 bk_rd_valid" : "R8 bk_rd_valid idle", 64'(bk_rd_valid), 64'(exp_rd_valid));
    check(re ? "R6 bk_rd_data" : "R8 bk_rd_data hold", 64'(bk_rd_data), 64'(exp_rd_data));
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bk_cmd_ready = 1'b1;
    #1;
    // R1 reset state
    check("R1 up_ready after reset", 64'(up_ready), 64'd1);
    check("R1 bk_cmd_slot after reset", 64'(bk_cmd_slot), 64'd0);
    check("R1 bk_rd_valid after reset", 64'(bk_rd_valid), 64'd0);
    check("R1 bk_rd_data after reset", 64'(bk_rd_data), 64'd0);
    @(negedge clk);

    // Fill back to back until full (R3 wrap later, R5 stall)
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 32'hA000_0000 + 32'(i), 0, 0);
    cyc(1, 1, 32'hDEAD_0001, 0, 0);
    cyc(1, 1, 32'hDEAD_0002, 0, 0);

    // Out-of-order frees (R6)
    cyc(0, 1, 0, 1, 2);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 1, 4);
    cyc(0, 1, 0, 0, 0);   // R8 hold

    // R4: write and free in the same cycle (slot 0 is free again)
    cyc(1, 1, 32'hB000_0000, 1, 1);
    // R2: no handshake without bk_cmd_ready or up_valid
    cyc(1, 0, 32'hC000_0000, 0, 0);
    cyc(0, 1, 32'hC000_0001, 0, 0);

    // Drain all live slots in order
    while (live.size() > 0) cyc(0, 1, 0, 1, live[0]);

    // R7: free with nothing pending, then exactly DEPTH writes before the stall
    cyc(0, 1, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 32'hE000_0000 + 32'(i), 0, 0);
    cyc(1, 1, 32'hE0FF_FFFF, 0, 0);
    while (live.size() > 0) cyc(0, 1, 0, 1, live[0]);

    // Randomised traffic with oldest-first frees
    for (int n = 0; n < 2000; n++) begin
      bit v, br, re;
      int rs;
      v  = ($urandom % 4) != 0;
      br = ($urandom % 5) != 0;
      if (live.size() > 0) begin
        re = ($urandom % 3) == 0;
        rs = live[0];
      end else begin
        re = ($urandom % 8) == 0;
        rs = 0;
      end
      cyc(v, br, $urandom, re, rs);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule